// File: doc/BRIEF.md
# Glitch-free clock output stop controller

This controller decides, cycle by cycle, whether each of eight differential clock output pairs toggles, is parked, or floats. It lives in the complement output clock domain. An asynchronous active-low power-down request is first synchronized, then has to be seen low on two consecutive rising edges of that clock before it counts as a confirmed stop. The pairs are then parked together on the next falling edge of the complement clock, so no output pulse is cut short. Only after the pairs are parked does the block ask the PLL to shut down.

The park encoding comes from a mode bit. In one mode the true leg is driven high and the complement leg floats. In the other mode both legs float. When the request is released, the PLL shutdown request is withdrawn and the block waits, for as long as it takes, for the PLL to report lock. Clocks resume on a falling edge of the complement clock, so the first pulse has full width. Each pair also has its own enable, and a disabled pair stays parked while the rest run.

Top module: `outpair_stop_ctrl`

## Requirements
- R1: After reset is released and before lock is reported, every pair is parked and `pll_off` is 0.
- R2: A stop is confirmed only when the synchronized request has been low on two consecutive rising edges of `cmp_clk`. A low pulse of one clock period on `pd_n`, or two one-period pulses with a high period between them, leaves all enabled pairs running and `pll_off` at 0.
- R3: The per-pair outputs (`pair_run`, `tru_hi`, `tru_z`, `cmp_z`) change only while `cmp_clk` is low. Parking takes effect on the first falling edge that follows the rising edge at which the stop is confirmed.
- R4: With `park_float`=0, a parked pair shows `pair_run`=0, `tru_hi`=1, `tru_z`=0 and `cmp_z`=1.
- R5: With `park_float`=1, a parked pair shows `pair_run`=0, `tru_hi`=0, `tru_z`=1 and `cmp_z`=1.
- R6: `pll_off` rises only after all pairs are parked, one rising edge after the park edge. While `pll_off` is 1, no pair runs.
- R7: After `pd_n` returns high, `pll_off` falls within four rising edges. The pairs stay parked until `pll_lock` is seen high on a rising edge, and they resume on the falling edge that follows.
- R8: A pair whose `pair_en` bit is 0 is parked in the current mode's encoding while the block is running. A pair whose bit is 1 runs. `pair_en` and `park_float` take effect on the next falling edge of `cmp_clk`.
- R9: A running pair shows `pair_run`=1, `tru_hi`=0, `tru_z`=0 and `cmp_z`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cmp_clk | input | 1 | Complement output clock. Rising edges sample the request; falling edges update the pair controls |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| park_float | input | 1 | Park mode: 0 = true leg high and complement floating, 1 = both legs floating |
| pair_en | input | 8 | Per-pair enable |
| pll_lock | input | 1 | PLL lock indication |
| pll_off | output | 1 | Request to shut the PLL down |
| pair_run | output | 8 | Pair toggles with the clock |
| tru_hi | output | 8 | True leg driven statically high |
| tru_z | output | 8 | True leg tri-stated |
| cmp_z | output | 8 | Complement leg tri-stated |

## Verification
The bench builds the block with its defaults: eight pairs, a two-edge confirmation and a two-stage synchronizer. With only eight pairs, every one of the 256 enable patterns can be swept in both park modes. A full stop and restart cycle is also run for several patterns in both modes. The request pulse widths of one and two periods sit exactly on the confirmation boundary. A long lock delay shows that the pairs are held parked, and a monitor flags any change of the pair controls while the complement clock is high.

// File: rtl/outpair_stop_pkg.sv
package outpair_stop_pkg;

    typedef enum logic [1:0] {
        ST_WAKE = 2'd0,
        ST_RUN  = 2'd1,
        ST_STOP = 2'd2,
        ST_DOWN = 2'd3
    } pwr_state_e;

endpackage

// File: rtl/req_sync.sv
module req_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_s;

    sync_s sync_d, sync_q;

    always_comb begin
        sync_d = sync_q;
        sync_d.chain = {sync_q.chain[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '{chain: {STAGES{RST_VAL}}};
        else        sync_q <= sync_d;
    end

    assign dout = sync_q.chain[STAGES-1];
endmodule

// File: rtl/stop_fsm.sv
module stop_fsm
    import outpair_stop_pkg::*;
#(
    parameter int CONFIRM = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_s,
    input  logic lock,
    input  logic park_done,
    output logic parking,
    output logic pll_off
);
    localparam int CW = $clog2(CONFIRM + 1);
    localparam logic [CW-1:0] CMAX = CW'(CONFIRM);

    typedef struct packed {
        pwr_state_e    state;
        logic [CW-1:0] cnt;
        logic          off;
    } fsm_s;

    fsm_s fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (pd_s)               fsm_d.cnt = '0;
        else if (fsm_q.cnt != CMAX) fsm_d.cnt = fsm_q.cnt + 1'b1;
        case (fsm_q.state)
            ST_WAKE: begin
                if (fsm_d.cnt == CMAX) fsm_d.state = ST_STOP;
                else if (lock)         fsm_d.state = ST_RUN;
            end
            ST_RUN: begin
                if (fsm_d.cnt == CMAX) fsm_d.state = ST_STOP;
            end
            ST_STOP: begin
                if (park_done) begin
                    fsm_d.state = ST_DOWN;
                    fsm_d.off   = 1'b1;
                end
            end
            default: begin
                if (pd_s) begin
                    fsm_d.state = ST_WAKE;
                    fsm_d.off   = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fsm_q <= '{state: ST_WAKE, cnt: '0, off: 1'b0};
        else        fsm_q <= fsm_d;
    end

    assign parking = (fsm_q.state != ST_RUN);
    assign pll_off = fsm_q.off;

    // R2: entry into the stop state needs the request low at the last two samples
    assert_two_edge_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_q.state == ST_STOP) |-> (!$past(pd_s) && $past(fsm_q.cnt) == CMAX - 1'b1));

    // R7: running resumes only after lock was observed
    assert_lock_before_run_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fsm_q.state == ST_RUN) |-> $past(lock));

    // R6: PLL shutdown only while the output stage reports parked
    assert_off_needs_park_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_q.off |-> park_done);
endmodule

// File: rtl/park_stage.sv
module park_stage #(
    parameter int NPAIR = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             park_req,
    input  logic [NPAIR-1:0] en,
    input  logic             flt,
    output logic             park_done,
    output logic [NPAIR-1:0] pair_run,
    output logic [NPAIR-1:0] tru_hi,
    output logic [NPAIR-1:0] tru_z,
    output logic [NPAIR-1:0] cmp_z
);
    typedef struct packed {
        logic             park;
        logic [NPAIR-1:0] en;
        logic             flt;
    } out_s;

    out_s out_d, out_q;

    always_comb begin
        out_d      = out_q;
        out_d.park = park_req;
        out_d.en   = en;
        out_d.flt  = flt;
    end

    // falling edge of the complement clock: every change lands in its low phase
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{park: 1'b1, en: '0, flt: 1'b0};
        else        out_q <= out_d;
    end

    assign park_done = out_q.park;

    for (genvar i = 0; i < NPAIR; i++) begin : g_pair
        logic parked;
        assign parked      = out_q.park | ~out_q.en[i];
        assign pair_run[i] = ~parked;
        assign tru_hi[i]   = parked & ~out_q.flt;
        assign tru_z[i]    = parked & out_q.flt;
        assign cmp_z[i]    = parked;
    end
endmodule

// File: rtl/outpair_stop_ctrl.sv
module outpair_stop_ctrl #(
    parameter int NPAIR    = 8,
    parameter int CONFIRM  = 2,
    parameter int SYNC_STG = 2
) (
    input  logic             cmp_clk,
    input  logic             rst_n,
    input  logic             pd_n,
    input  logic             park_float,
    input  logic [NPAIR-1:0] pair_en,
    input  logic             pll_lock,
    output logic             pll_off,
    output logic [NPAIR-1:0] pair_run,
    output logic [NPAIR-1:0] tru_hi,
    output logic [NPAIR-1:0] tru_z,
    output logic [NPAIR-1:0] cmp_z
);
    logic pd_s;
    logic parking;
    logic park_done;

    req_sync #(.STAGES(SYNC_STG), .RST_VAL(1'b1)) u_sync (
        .clk(cmp_clk), .rst_n(rst_n), .din(pd_n), .dout(pd_s)
    );

    stop_fsm #(.CONFIRM(CONFIRM)) u_fsm (
        .clk(cmp_clk), .rst_n(rst_n), .pd_s(pd_s), .lock(pll_lock),
        .park_done(park_done), .parking(parking), .pll_off(pll_off)
    );

    park_stage #(.NPAIR(NPAIR)) u_park (
        .clk(cmp_clk), .rst_n(rst_n), .park_req(parking), .en(pair_en),
        .flt(park_float), .park_done(park_done), .pair_run(pair_run),
        .tru_hi(tru_hi), .tru_z(tru_z), .cmp_z(cmp_z)
    );

    // R6: no pair toggles while the PLL is told to stop
    assert_quiet_when_off_R6: assert property (@(posedge cmp_clk) disable iff (!rst_n)
        pll_off |-> (pair_run == '0));

    // R8: a pair held disabled never runs
    for (genvar i = 0; i < NPAIR; i++) begin : g_chk
        assert_disabled_parked_R8: assert property (@(posedge cmp_clk) disable iff (!rst_n)
            (!$past(pair_en[i]) && !pair_en[i]) |-> !pair_run[i]);
    end
endmodule

// File: tb/tb_outpair_stop_ctrl.sv
module tb_outpair_stop_ctrl;
    localparam int  N  = 8;
    localparam time TP = 10;

    logic         cmp_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pd_n = 1'b1;
    logic         park_float = 1'b0;
    logic [N-1:0] pair_en = '1;
    logic         pll_lock = 1'b0;
    logic         pll_off;
    logic [N-1:0] pair_run, tru_hi, tru_z, cmp_z;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(TP/2) cmp_clk = ~cmp_clk;

    outpair_stop_ctrl dut (
        .cmp_clk(cmp_clk), .rst_n(rst_n), .pd_n(pd_n), .park_float(park_float),
        .pair_en(pair_en), .pll_lock(pll_lock), .pll_off(pll_off),
        .pair_run(pair_run), .tru_hi(tru_hi), .tru_z(tru_z), .cmp_z(cmp_z)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected pair controls for a run mask and park mode (R4, R5, R9)
    task automatic chk_pairs(input string req, input logic [N-1:0] run, input logic flt);
        logic [N-1:0] pk;
        pk = ~run;
        chk({req, " run"}, 32'(pair_run), 32'(run));
        chk({req, " tru_hi"}, 32'(tru_hi), 32'(flt ? '0 : pk));
        chk({req, " tru_z"}, 32'(tru_z), 32'(flt ? pk : '0));
        chk({req, " cmp_z"}, 32'(cmp_z), 32'(pk));
    endtask

    task automatic after_neg(); @(negedge cmp_clk); #2; endtask
    task automatic after_pos(); @(posedge cmp_clk); #2; endtask

    // R3: runt monitor, any pair control change must fall in the low phase
    always @(pair_run or tru_hi or tru_z or cmp_z) begin
        if (rst_n && $time > 0) chk("R3 change in low phase", 32'(cmp_clk), 32'h0);
    end

    // full stop and restart cycle
    task automatic pd_cycle(input logic flt, input logic [N-1:0] en);
        park_float = flt;
        pair_en    = en;
        after_neg(); after_neg();
        chk_pairs("R8 R9 running before stop", en, flt);
        pd_n = 1'b0;
        pll_lock = 1'b0;
        for (int k = 0; k < 4; k++) after_pos();
        chk_pairs("R3 not parked before falling edge", en, flt);
        after_neg();
        chk_pairs(flt ? "R5 park encoding" : "R4 park encoding", '0, flt);
        chk("R6 off after park only", 32'(pll_off), 32'h0);
        after_pos();
        chk("R6 pll_off raised", 32'(pll_off), 32'h1);
        for (int k = 0; k < 3; k++) after_neg();
        pd_n = 1'b1;
        for (int k = 0; k < 4; k++) after_pos();
        chk("R7 pll_off released", 32'(pll_off), 32'h0);
        for (int k = 0; k < 150; k++) after_neg();
        chk_pairs("R7 parked while unlocked", '0, flt);
        pll_lock = 1'b1;
        after_pos();
        chk_pairs("R7 parked until falling edge", '0, flt);
        after_neg();
        chk_pairs("R7 resumed after lock", en, flt);
    endtask

    initial begin
        #(TP * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(3 * TP);
        rst_n = 1'b1;
        after_neg(); after_neg();
        chk_pairs("R1 parked after reset", '0, 1'b0);
        chk("R1 pll_off after reset", 32'(pll_off), 32'h0);
        pll_lock = 1'b1;
        after_pos(); after_neg();
        chk_pairs("R9 running after lock", '1, 1'b0);

        // R8 / R4 / R5 / R9: sweep every enable pattern in both modes
        for (int m = 0; m < 2; m++) begin
            for (int p = 0; p < (1 << N); p++) begin
                park_float = m[0];
                pair_en = N'(p);
                after_neg(); after_neg();
                chk_pairs("R8 enable sweep", N'(p), m[0]);
            end
        end

        // R2: one-period low pulse is rejected
        pair_en = '1; park_float = 1'b0;
        after_neg();
        pd_n = 1'b0; after_neg(); pd_n = 1'b1;
        for (int k = 0; k < 8; k++) after_neg();
        chk_pairs("R2 single pulse ignored", '1, 1'b0);
        chk("R2 pll_off after single pulse", 32'(pll_off), 32'h0);
        // R2: two separated one-period pulses are rejected
        pd_n = 1'b0; after_neg(); pd_n = 1'b1; after_neg();
        pd_n = 1'b0; after_neg(); pd_n = 1'b1;
        for (int k = 0; k < 8; k++) after_neg();
        chk_pairs("R2 split pulses ignored", '1, 1'b0);
        chk("R2 pll_off after split pulses", 32'(pll_off), 32'h0);
        // R2: two-period low pulse is accepted
        pll_lock = 1'b0;
        pd_n = 1'b0; after_neg(); after_neg(); pd_n = 1'b1;
        for (int k = 0; k < 4; k++) after_neg();
        chk_pairs("R2 two-period pulse parks", '0, 1'b0);
        pll_lock = 1'b1;
        for (int k = 0; k < 4; k++) after_neg();
        chk_pairs("R7 resumed after short stop", '1, 1'b0);

        pd_cycle(1'b0, 8'hFF);
        pd_cycle(1'b1, 8'hFF);
        pd_cycle(1'b0, 8'hA5);
        pd_cycle(1'b1, 8'h3C);
        pd_cycle(1'b1, 8'h00);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule